// File: doc/BRIEF.md
# Write-Enable and Block-Protection Status Unit

This unit owns the status state of a small serial non-volatile memory. That state is a write-enable latch, a two-bit block-protect level and a busy flag. It also decides whether each programming request may start. An instruction decoder upstream presents one-cycle strobes: set-enable, clear-enable, status-write (with a data byte) and array-write (with an 11-bit address). The unit checks each strobe against the write-protect pin, the enable latch, the busy flag and the protected address window.

An accepted array write pulses a grant to the array sequencer and starts a busy period. An accepted status write loads the protect level and also starts a busy period. The sequencer ends the period with a done pulse, and that pulse also drops the enable latch, so every program cycle needs a fresh set-enable.

The status byte is presented continuously for the serial read path. It reads as all ones while a program cycle is running.

Top module: `prot_status_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `status_o` is 8'h00, `busy_o` is 0 and `write_grant_o` is 0. This means the enable latch is clear and the protect level is 00.
- R2: When idle, a set-enable strobe sets the enable latch (status bit 1) one cycle later, and a clear-enable strobe clears it one cycle later.
- R3: An array write is accepted only if `wp_i` is high, the enable latch is set and the address is outside the protected window. Acceptance raises `write_grant_o` for exactly one cycle, starting the cycle after the strobe, and sets `busy_o` (status bit 0) in that same cycle.
- R4: The protect level is status bits 3:2. Level 00 protects nothing, 01 protects 0x600–0x7FF, 10 protects 0x400–0x7FF and 11 protects 0x000–0x7FF.
- R5: A rejected array write or status write gives no grant and no busy period, and leaves the enable latch as it was.
- R6: A status write is accepted only if `wp_i` is high and the enable latch is set. It loads bits 3:2 of `wrsr_data_i` into the protect level, ignores the other data bits and starts a busy period.
- R7: While `busy_o` is 1, `status_o` reads 8'hFF.
- R8: A `prog_done_i` pulse during a busy period clears `busy_o` and the enable latch one cycle later. A pulse while idle has no effect.
- R9: While busy, set-enable, clear-enable, array-write and status-write strobes are all ignored.
- R10: If several strobes arrive together, only one is considered, in this priority: array write, then status write, then clear-enable, then set-enable.
- R11: When idle, status bits 7:4 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wren_stb_i | input | 1 | Set-enable instruction strobe |
| wrdi_stb_i | input | 1 | Clear-enable instruction strobe |
| wrsr_stb_i | input | 1 | Status-write instruction strobe |
| wrsr_data_i | input | 8 | Status-write data byte |
| write_stb_i | input | 1 | Array-write instruction strobe |
| write_addr_i | input | 11 | Array-write target address |
| wp_i | input | 1 | Write-protect pin level, high allows programming |
| prog_done_i | input | 1 | End-of-program-cycle pulse from the array sequencer |
| write_grant_o | output | 1 | One-cycle permit for an accepted array write |
| busy_o | output | 1 | Program cycle in progress |
| status_o | output | 8 | Status byte for the read path |

## Verification
Every result of this unit appears one register stage after its cause. A strobe or done pulse is driven at the falling edge, captured at the next rising edge, and the grant, busy flag, enable latch and protect level are all visible just after that edge. The status byte is a combinational view of those registers, so it changes in that same cycle. Each bench task therefore drives a stimulus, waits for exactly one rising edge plus a small delay, and compares at that point. The one-cycle grant is also checked to be low in the following cycle.

// File: rtl/prot_status_pkg.sv
package prot_status_pkg;

    localparam int STAT_W = 8;

    typedef logic [1:0] bp_t;

    typedef enum logic [2:0] {
        CMD_NONE  = 3'd0,
        CMD_WREN  = 3'd1,
        CMD_WRDI  = 3'd2,
        CMD_WRSR  = 3'd3,
        CMD_WRITE = 3'd4
    } cmd_e;

    typedef struct packed {
        logic write;
        logic wrsr;
        logic wrdi;
        logic wren;
    } strobe_t;

    // Highest-priority strobe wins; lower ones in the same cycle are dropped.
    function automatic cmd_e pick_cmd(strobe_t s);
        if (s.write)     return CMD_WRITE;
        else if (s.wrsr) return CMD_WRSR;
        else if (s.wrdi) return CMD_WRDI;
        else if (s.wren) return CMD_WREN;
        else             return CMD_NONE;
    endfunction

    function automatic logic [STAT_W-1:0] pack_status(logic busy, bp_t bp, logic wen);
        if (busy) return '1;
        return {4'b0000, bp, wen, 1'b0};
    endfunction

endpackage

// File: rtl/psu_cmd_arbiter.sv
module psu_cmd_arbiter
    import prot_status_pkg::*;
(
    input  strobe_t strobes_i,
    input  logic    busy_i,
    input  logic    wp_i,
    input  logic    wen_i,
    input  logic    hit_i,
    output cmd_e    cmd_o
);

    cmd_e top_cmd;

    always_comb begin
        top_cmd = pick_cmd(strobes_i);
        cmd_o   = CMD_NONE;
        if (!busy_i) begin
            unique case (top_cmd)
                CMD_WRITE: if (wp_i && wen_i && !hit_i) cmd_o = CMD_WRITE;
                CMD_WRSR:  if (wp_i && wen_i)           cmd_o = CMD_WRSR;
                CMD_WRDI:  cmd_o = CMD_WRDI;
                CMD_WREN:  cmd_o = CMD_WREN;
                default:   cmd_o = CMD_NONE;
            endcase
        end
    end

endmodule

// File: rtl/psu_range_cmp.sv
module psu_range_cmp
    import prot_status_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  bp_t               bp_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o
);

    localparam logic [ADDR_W-1:0] TOP_QTR_BASE = ADDR_W'(3) << (ADDR_W - 2);
    localparam logic [ADDR_W-1:0] TOP_HALF_BASE = ADDR_W'(1) << (ADDR_W - 1);

    always_comb begin
        unique case (bp_i)
            2'b00:   hit_o = 1'b0;
            2'b01:   hit_o = (addr_i >= TOP_QTR_BASE);
            2'b10:   hit_o = (addr_i >= TOP_HALF_BASE);
            default: hit_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/psu_status_regs.sv
module psu_status_regs
    import prot_status_pkg::*;
#(
    parameter bp_t BP_RST = 2'b00
) (
    input  logic clk,
    input  logic rst,
    input  cmd_e cmd_i,
    input  bp_t  bp_data_i,
    input  logic cycle_end_i,
    output logic wen_o,
    output bp_t  bp_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            wen_o <= 1'b0;
            bp_o  <= BP_RST;
        end else begin
            if (cycle_end_i)             wen_o <= 1'b0;
            else if (cmd_i == CMD_WREN)  wen_o <= 1'b1;
            else if (cmd_i == CMD_WRDI)  wen_o <= 1'b0;
            if (cmd_i == CMD_WRSR)       bp_o  <= bp_data_i;
        end
    end

    // R8
    cyc_end_clears_wen_chk: assert property (@(posedge clk) disable iff (rst)
        cycle_end_i |=> !wen_o);

    // R6
    bp_only_by_wrsr_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(bp_o) |-> $past(cmd_i == CMD_WRSR));

endmodule

// File: rtl/psu_busy_ctrl.sv
module psu_busy_ctrl
    import prot_status_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cmd_e cmd_i,
    input  logic prog_done_i,
    output logic busy_o,
    output logic grant_o,
    output logic cycle_end_o
);

    assign cycle_end_o = busy_o & prog_done_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o  <= 1'b0;
            grant_o <= 1'b0;
        end else begin
            if (cycle_end_o)
                busy_o <= 1'b0;
            else if (cmd_i == CMD_WRITE || cmd_i == CMD_WRSR)
                busy_o <= 1'b1;
            grant_o <= (cmd_i == CMD_WRITE);
        end
    end

    // R3
    grant_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        grant_o |-> busy_o);

    // R3
    grant_single_chk: assert property (@(posedge clk) disable iff (rst)
        grant_o |=> !grant_o);

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o && !prog_done_i |=> busy_o);

endmodule

// File: rtl/prot_status_unit.sv
module prot_status_unit
    import prot_status_pkg::*;
#(
    parameter int  ADDR_W = 11,
    parameter bp_t BP_RST = 2'b00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wren_stb_i,
    input  logic              wrdi_stb_i,
    input  logic              wrsr_stb_i,
    input  logic [7:0]        wrsr_data_i,
    input  logic              write_stb_i,
    input  logic [ADDR_W-1:0] write_addr_i,
    input  logic              wp_i,
    input  logic              prog_done_i,
    output logic              write_grant_o,
    output logic              busy_o,
    output logic [7:0]        status_o
);

    strobe_t strobes;
    cmd_e    cmd;
    logic    wen_q;
    bp_t     bp_q;
    logic    prot_hit;
    logic    cycle_end;
    logic    unused_data_bits;

    assign strobes = '{write: write_stb_i, wrsr: wrsr_stb_i,
                       wrdi: wrdi_stb_i,   wren: wren_stb_i};
    assign unused_data_bits = ^{wrsr_data_i[7:4], wrsr_data_i[1:0]};

    psu_range_cmp #(.ADDR_W(ADDR_W)) u_range (
        .bp_i   (bp_q),
        .addr_i (write_addr_i),
        .hit_o  (prot_hit)
    );

    psu_cmd_arbiter u_arb (
        .strobes_i (strobes),
        .busy_i    (busy_o),
        .wp_i      (wp_i),
        .wen_i     (wen_q),
        .hit_i     (prot_hit),
        .cmd_o     (cmd)
    );

    psu_status_regs #(.BP_RST(BP_RST)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .cmd_i       (cmd),
        .bp_data_i   (wrsr_data_i[3:2]),
        .cycle_end_i (cycle_end),
        .wen_o       (wen_q),
        .bp_o        (bp_q)
    );

    psu_busy_ctrl u_busy (
        .clk         (clk),
        .rst         (rst),
        .cmd_i       (cmd),
        .prog_done_i (prog_done_i),
        .busy_o      (busy_o),
        .grant_o     (write_grant_o),
        .cycle_end_o (cycle_end)
    );

    assign status_o = pack_status(busy_o, bp_q, wen_q);

    // R3
    grant_qualified_chk: assert property (@(posedge clk) disable iff (rst)
        write_grant_o |-> $past(wp_i) && $past(wen_q) && !$past(prot_hit));

    // R5
    busy_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(wen_q) && $past(wp_i));

    // R9
    frozen_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o && !prog_done_i |=> $stable(wen_q) && $stable(bp_q));

endmodule

// File: tb/prot_status_unit_tb.sv
`timescale 1ns/1ps
module prot_status_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wren_stb = 1'b0, wrdi_stb = 1'b0, wrsr_stb = 1'b0, write_stb = 1'b0;
    logic [7:0]  wrsr_data = 8'h00;
    logic [10:0] write_addr = 11'h000;
    logic        wp = 1'b1;
    logic        prog_done = 1'b0;
    logic        write_grant, busy;
    logic [7:0]  status;

    int checks = 0;
    int fails  = 0;
    logic [1:0] cur_bp = 2'b00;

    always #4 clk = ~clk;

    prot_status_unit u_dut (
        .clk           (clk),
        .rst           (rst),
        .wren_stb_i    (wren_stb),
        .wrdi_stb_i    (wrdi_stb),
        .wrsr_stb_i    (wrsr_stb),
        .wrsr_data_i   (wrsr_data),
        .write_stb_i   (write_stb),
        .write_addr_i  (write_addr),
        .wp_i          (wp),
        .prog_done_i   (prog_done),
        .write_grant_o (write_grant),
        .busy_o        (busy),
        .status_o      (status)
    );

    function automatic logic [7:0] exp_stat(logic b, logic [1:0] bp, logic wen);
        return b ? 8'hFF : {4'b0000, bp, wen, 1'b0};
    endfunction

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One-cycle stimulus: driven at falling edge, results sampled just after the next rising edge.
    task automatic pulse(input logic en, input logic di, input logic sr, input logic wr,
                         input logic [7:0] d, input logic [10:0] a, input logic dn);
        @(negedge clk);
        wren_stb = en; wrdi_stb = di; wrsr_stb = sr; write_stb = wr;
        wrsr_data = d; write_addr = a; prog_done = dn;
        @(posedge clk);
        #1;
        wren_stb = 0; wrdi_stb = 0; wrsr_stb = 0; write_stb = 0; prog_done = 0;
    endtask

    task automatic do_wren();  pulse(1,0,0,0,8'h00,11'h000,0); endtask
    task automatic do_wrdi();  pulse(0,1,0,0,8'h00,11'h000,0); endtask
    task automatic do_done();  pulse(0,0,0,0,8'h00,11'h000,1); endtask
    task automatic do_write(input logic [10:0] a); pulse(0,0,0,1,8'h00,a,0); endtask
    task automatic do_wrsr(input logic [7:0] d);   pulse(0,0,1,0,d,11'h000,0); endtask

    task automatic t_reset();
        chk("R1", "status after reset", status, 8'h00);
        chk("R1", "busy after reset", {7'd0, busy}, 8'h00);
        chk("R1", "grant after reset", {7'd0, write_grant}, 8'h00);
    endtask

    task automatic t_enable();
        do_wren();
        chk("R2", "wren sets latch", status, 8'h02);
        chk("R11", "upper bits idle", {4'd0, status[7:4]}, 8'h00);
        do_wrdi();
        chk("R2", "wrdi clears latch", status, 8'h00);
    endtask

    task automatic t_reject();
        do_write(11'h000);
        chk("R5", "grant without latch", {7'd0, write_grant}, 8'h00);
        chk("R5", "status without latch", status, 8'h00);
        do_wren();
        wp = 1'b0;
        do_write(11'h010);
        chk("R5", "grant with wp low", {7'd0, write_grant}, 8'h00);
        chk("R5", "latch kept after wp reject", status, 8'h02);
        do_wrsr(8'h0C);
        chk("R5", "wrsr with wp low", status, 8'h02);
        wp = 1'b1;
        do_wrdi();
        do_wrsr(8'h0C);
        chk("R6", "wrsr without latch", status, 8'h00);
    endtask

    task automatic t_write_busy();
        do_wren();
        do_write(11'h123);
        chk("R3", "grant on accepted write", {7'd0, write_grant}, 8'h01);
        chk("R7", "status while busy", status, 8'hFF);
        do_wrsr(8'h0C);
        chk("R3", "grant lasts one cycle", {7'd0, write_grant}, 8'h00);
        chk("R9", "wrsr ignored while busy", status, 8'hFF);
        do_write(11'h020);
        chk("R9", "write ignored while busy", {7'd0, write_grant}, 8'h00);
        do_wrdi();
        do_wren();
        chk("R7", "still busy", {7'd0, busy}, 8'h01);
        do_done();
        chk("R8", "done clears busy and latch", status, exp_stat(0, 2'b00, 0));
        do_wren();
        do_done();
        chk("R8", "done while idle no effect", status, 8'h02);
        do_wrdi();
    endtask

    task automatic set_bp(input logic [1:0] lvl);
        do_wren();
        do_wrsr({4'b1010, lvl, 2'b11});
        chk("R6", "wrsr starts busy", {7'd0, busy}, 8'h01);
        do_done();
        cur_bp = lvl;
        chk("R6", "protect level loaded", status, exp_stat(0, lvl, 0));
    endtask

    task automatic try_write(input logic [10:0] a, input logic ok);
        do_wren();
        do_write(a);
        chk("R4", $sformatf("grant at bp=%0d addr=%h", cur_bp, a), {7'd0, write_grant}, {7'd0, ok});
        if (ok) begin
            do_done();
            chk("R8", "status after write done", status, exp_stat(0, cur_bp, 0));
        end else begin
            chk("R5", "latch kept after range reject", status, exp_stat(0, cur_bp, 1));
            do_wrdi();
        end
    endtask

    task automatic t_protect();
        set_bp(2'b01);
        try_write(11'h5FF, 1);
        try_write(11'h600, 0);
        try_write(11'h7FF, 0);
        set_bp(2'b10);
        try_write(11'h3FF, 1);
        try_write(11'h400, 0);
        set_bp(2'b11);
        try_write(11'h000, 0);
        set_bp(2'b00);
        try_write(11'h7FF, 1);
    endtask

    task automatic t_priority();
        pulse(1,1,0,0,8'h00,11'h000,0);
        chk("R10", "wrdi beats wren", status, 8'h00);
        do_wren();
        pulse(0,0,1,1,8'h0C,11'h100,0);
        chk("R10", "write beats wrsr", {7'd0, write_grant}, 8'h01);
        do_done();
        chk("R10", "protect level untouched", status, 8'h00);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        t_reset();
        t_enable();
        t_reject();
        t_write_busy();
        t_protect();
        t_priority();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule